// File: doc/BRIEF.md
# BCD time and calendar counter

This block keeps wall-clock time (hours, minutes, seconds) and a calendar (century, year, month, date, day of week) in packed BCD words. It advances on a single-cycle `sec_tick` strobe, which a slow-clock divider outside the block produces once per second. A small register bus gives software access to a control word, a status word, a clear-command word, the time word, the calendar word and a valid-entry word.

Software sets the time by raising an update request in the control word. Each request freezes its own counter. The block acknowledges on the next second tick, so a freeze never cuts a second short. Software then writes the new time or calendar word and drops the request, and counting resumes from the written value. A value with a bad BCD digit or a field out of range is refused. It raises an invalid flag and keeps the counter frozen until a good value arrives.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the control word, status word and valid-entry word read 0. The time word reads 0x00000000 (00:00:00). The calendar word reads 0x01210019 (century 19, year 00, month 01, day of week 1, date 01).
- R2: Time word layout is seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, all BCD. On each tick, seconds count 00..59 and carry into minutes. Minutes count 00..59 and carry into hours. Hours count 00..23 and wrap to 00, and the step past 23:59:59 advances the calendar by one day.
- R3: Calendar word layout is century in bits 6:0, year in bits 15:8, month in bits 20:16, day of week in bits 23:21 and date in bits 29:24, all BCD. On a day step, day of week wraps from 7 to 1. The date wraps to 01 after the month's last day (30 for months 04, 06, 09, 11; 31 for the other months except 02). Month 12 wraps to 01 with a year step. Year 99 wraps to 00 with a century step.
- R4: February has 29 days when the year is not 00 and is divisible by 4. It also has 29 days when the year is 00 and the century is divisible by 4. Otherwise it has 28 days: 2024 and 2000 are leap years, 1900 and 2023 are not.
- R5: Control bit 0 freezes the time counter and control bit 1 freezes the calendar counter, each independently. While the calendar is frozen, a day carry from the running time counter is dropped.
- R6: Status bit 0 (acknowledge) is set only on a tick during which a control request bit is set. It is cleared by writing 1 to bit 0 of the clear-command word or by writing the control word with both request bits zero.
- R7: A write to the time word takes effect only while control bit 0 and the acknowledge are both set. A write to the calendar word takes effect only while control bit 1 and the acknowledge are both set. Any other write to these words is ignored.
- R8: Status bit 2 (second event) is set on every tick. It is cleared by writing 1 to bit 2 of the clear-command word. A tick in the same cycle as the clear leaves it set.
- R9: An accepted time or calendar write with a BCD digit above 9 or a field out of range leaves the counter value unchanged. It sets valid-entry bit 0 (time) or bit 1 (calendar), and that counter stays frozen until a valid write clears the flag. Valid ranges are: hours 00..23, minutes and seconds 00..59, century 19..20, month 01..12, day of week 1..7, date 01..month length.
- R10: Time word bit 22 (AM/PM indicator) and all bits outside the fields read 0, whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register index: 0 control, 1 status, 2 clear command, 3 time, 4 calendar, 5 valid entry |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The bench uses the default parameters: a three-bit register index and a century window of 19 to 20. With that window, 1900, 1999→2000 and the 2020s can all be preset through the update handshake. The bench drives `sec_tick` directly, so every rollover is reached within a few cycles of a preset. This covers month ends of each length, both leap-year exceptions, the century step, frozen-counter and dropped-carry cases, and refused entries.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int unsigned WORD_W = 32;

  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_STAT  = 1;
  localparam int unsigned OFF_CLR   = 2;
  localparam int unsigned OFF_TIME  = 3;
  localparam int unsigned OFF_CAL   = 4;
  localparam int unsigned OFF_VALID = 5;

  typedef struct packed {
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } clk_time_t;

  typedef struct packed {
    logic [5:0] date;
    logic [2:0] dow;
    logic [4:0] month;
    logic [7:0] year;
    logic [6:0] cent;
  } clk_cal_t;

  // two BCD digits both in 0..9
  function automatic logic digits_ok(input logic [7:0] b);
    return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd9);
  endfunction

  // two-digit BCD to binary
  function automatic logic [6:0] bcd_val(input logic [7:0] b);
    return (7'(b[7:4]) * 7'd10) + 7'(b[3:0]);
  endfunction

  // two-digit BCD increment (no wrap beyond 99 needed by callers)
  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [6:0] cent, input logic [7:0] year);
    logic [6:0] yv;
    logic [6:0] cv;
    yv = bcd_val(year);
    cv = bcd_val({1'b0, cent});
    if (yv == 7'd0) return (cv[1:0] == 2'd0);
    return (yv[1:0] == 2'd0);
  endfunction

  function automatic logic [6:0] month_days(input logic [4:0] month, input logic leap);
    case (month)
      5'h02:                      return leap ? 7'd29 : 7'd28;
      5'h04, 5'h06, 5'h09, 5'h11: return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  function automatic clk_time_t word_to_time(input logic [WORD_W-1:0] w);
    clk_time_t t;
    t.sec  = w[6:0];
    t.min  = w[14:8];
    t.hour = w[21:16];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] time_to_word(input clk_time_t t);
    return {10'd0, 1'b0, t.hour, 1'b0, t.min, 1'b0, t.sec};
  endfunction

  function automatic clk_cal_t word_to_cal(input logic [WORD_W-1:0] w);
    clk_cal_t c;
    c.cent  = w[6:0];
    c.year  = w[15:8];
    c.month = w[20:16];
    c.dow   = w[23:21];
    c.date  = w[29:24];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cal_to_word(input clk_cal_t c);
    return {2'd0, c.date, c.dow, c.month, c.year, 1'b0, c.cent};
  endfunction

  function automatic logic time_ok(input clk_time_t t);
    logic d;
    d = digits_ok({1'b0, t.sec}) && digits_ok({1'b0, t.min}) && digits_ok({2'b0, t.hour});
    return d && (t.sec <= 7'h59) && (t.min <= 7'h59) && (t.hour <= 6'h23);
  endfunction

  function automatic logic cal_ok(input clk_cal_t c, input int unsigned cent_lo,
                                  input int unsigned cent_hi);
    logic       d;
    logic [6:0] cv;
    logic [6:0] dv;
    d  = digits_ok({1'b0, c.cent}) && digits_ok(c.year) &&
         digits_ok({3'b0, c.month}) && digits_ok({2'b0, c.date});
    cv = bcd_val({1'b0, c.cent});
    dv = bcd_val({2'b0, c.date});
    if (!d) return 1'b0;
    if ((32'(cv) < cent_lo) || (32'(cv) > cent_hi)) return 1'b0;
    if ((c.month == 5'h00) || (c.month > 5'h12)) return 1'b0;
    if ((c.dow == 3'd0)) return 1'b0;
    if ((dv == 7'd0) || (dv > month_days(c.month, is_leap(c.cent, c.year)))) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/bcd_rtc_time_cnt.sv
module bcd_rtc_time_cnt
  import bcd_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      run,
  input  logic      load,
  input  clk_time_t load_val,
  output clk_time_t time_q,
  output logic      day_carry
);

  clk_time_t nxt;
  logic      sec_end;
  logic      min_end;
  logic      hour_end;

  assign sec_end  = (time_q.sec == 7'h59);
  assign min_end  = (time_q.min == 7'h59);
  assign hour_end = (time_q.hour == 6'h23);

  always_comb begin
    nxt = time_q;
    if (!sec_end) begin
      nxt.sec = 7'(bcd_inc({1'b0, time_q.sec}));
    end else begin
      nxt.sec = '0;
      if (!min_end) begin
        nxt.min = 7'(bcd_inc({1'b0, time_q.min}));
      end else begin
        nxt.min = '0;
        if (hour_end) nxt.hour = '0;
        else          nxt.hour = 6'(bcd_inc({2'b0, time_q.hour}));
      end
    end
  end

  assign day_carry = tick && run && sec_end && min_end && hour_end;

  always_ff @(posedge clk) begin
    if (!rst_n)           time_q <= '0;
    else if (load)        time_q <= load_val;
    else if (tick && run) time_q <= nxt;
  end

endmodule

// File: rtl/bcd_rtc_cal_cnt.sv
module bcd_rtc_cal_cnt
  import bcd_rtc_pkg::*;
#(
  parameter logic [31:0] RESET_CAL = 32'h0121_0019
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     load,
  input  clk_cal_t load_val,
  output clk_cal_t cal_q
);

  localparam clk_cal_t CAL_INIT = word_to_cal(RESET_CAL);

  clk_cal_t   nxt;
  logic [6:0] last_day;
  logic [6:0] date_bin;

  assign last_day = month_days(cal_q.month, is_leap(cal_q.cent, cal_q.year));
  assign date_bin = bcd_val({2'b0, cal_q.date});

  always_comb begin
    nxt     = cal_q;
    nxt.dow = (cal_q.dow == 3'd7) ? 3'd1 : cal_q.dow + 3'd1;
    if (date_bin < last_day) begin
      nxt.date = 6'(bcd_inc({2'b0, cal_q.date}));
    end else begin
      nxt.date = 6'h01;
      if (cal_q.month != 5'h12) begin
        nxt.month = 5'(bcd_inc({3'b0, cal_q.month}));
      end else begin
        nxt.month = 5'h01;
        if (cal_q.year != 8'h99) begin
          nxt.year = bcd_inc(cal_q.year);
        end else begin
          nxt.year = 8'h00;
          nxt.cent = 7'(bcd_inc({1'b0, cal_q.cent}));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cal_q <= CAL_INIT;
    else if (load) cal_q <= load_val;
    else if (step) cal_q <= nxt;
  end

endmodule

// File: rtl/bcd_rtc_ctrl.sv
module bcd_rtc_ctrl
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned CENT_LO = 19,
  parameter int unsigned CENT_HI = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] time_word,
  input  logic [WORD_W-1:0] cal_word,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              time_load,
  output clk_time_t         time_load_val,
  output logic              cal_load,
  output clk_cal_t          cal_load_val,
  output logic              time_run,
  output logic              cal_run,
  output logic              upd_tim,
  output logic              upd_cal,
  output logic              ack,
  output logic              sec_evt,
  output logic              nv_tim,
  output logic              nv_cal
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFF_TIME);
  localparam logic [ADDR_W-1:0] A_CAL   = ADDR_W'(OFF_CAL);
  localparam logic [ADDR_W-1:0] A_VALID = ADDR_W'(OFF_VALID);

  logic ctrl_wr;
  logic clr_wr;
  logic time_wr_ok;
  logic cal_wr_ok;
  logic time_good;
  logic cal_good;

  assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
  assign clr_wr     = bus_wr && (bus_addr == A_CLR);
  assign time_wr_ok = bus_wr && (bus_addr == A_TIME) && upd_tim && ack;
  assign cal_wr_ok  = bus_wr && (bus_addr == A_CAL)  && upd_cal && ack;

  assign time_load_val = word_to_time(bus_wdata);
  assign cal_load_val  = word_to_cal(bus_wdata);
  assign time_good     = time_ok(time_load_val);
  assign cal_good      = cal_ok(cal_load_val, CENT_LO, CENT_HI);
  assign time_load     = time_wr_ok && time_good;
  assign cal_load      = cal_wr_ok && cal_good;

  assign time_run = !upd_tim && !nv_tim;
  assign cal_run  = !upd_cal && !nv_cal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_tim <= 1'b0;
      upd_cal <= 1'b0;
    end else if (ctrl_wr) begin
      upd_tim <= bus_wdata[0];
      upd_cal <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   ack <= 1'b0;
    else if (ctrl_wr && (bus_wdata[1:0] == 2'b00)) ack <= 1'b0;
    else if (tick && (upd_tim || upd_cal))        ack <= 1'b1;
    else if (clr_wr && bus_wdata[0])              ack <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      sec_evt <= 1'b0;
    else if (tick)                   sec_evt <= 1'b1;
    else if (clr_wr && bus_wdata[2]) sec_evt <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nv_tim <= 1'b0;
      nv_cal <= 1'b0;
    end else begin
      if (time_wr_ok) nv_tim <= !time_good;
      if (cal_wr_ok)  nv_cal <= !cal_good;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {30'd0, upd_cal, upd_tim};
      A_STAT:  bus_rdata = {29'd0, sec_evt, 1'b0, ack};
      A_TIME:  bus_rdata = time_word;
      A_CAL:   bus_rdata = cal_word;
      A_VALID: bus_rdata = {30'd0, nv_cal, nv_tim};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned CENT_LO   = 19,
  parameter int unsigned CENT_HI   = 20,
  parameter logic [31:0] RESET_CAL = 32'h0121_0019
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  clk_time_t         time_q;
  clk_time_t         time_load_val;
  clk_cal_t          cal_q;
  clk_cal_t          cal_load_val;
  logic [WORD_W-1:0] time_word;
  logic [WORD_W-1:0] cal_word;
  logic              time_load;
  logic              cal_load;
  logic              time_run;
  logic              cal_run;
  logic              day_carry;
  logic              day_step;
  logic              upd_tim;
  logic              upd_cal;
  logic              ack;
  logic              sec_evt;
  logic              nv_tim;
  logic              nv_cal;

  assign time_word = time_to_word(time_q);
  assign cal_word  = cal_to_word(cal_q);
  assign day_step  = day_carry && cal_run;

  bcd_rtc_ctrl #(
    .ADDR_W (ADDR_W),
    .CENT_LO(CENT_LO),
    .CENT_HI(CENT_HI)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (sec_tick),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .time_word    (time_word),
    .cal_word     (cal_word),
    .bus_rdata    (bus_rdata),
    .time_load    (time_load),
    .time_load_val(time_load_val),
    .cal_load     (cal_load),
    .cal_load_val (cal_load_val),
    .time_run     (time_run),
    .cal_run      (cal_run),
    .upd_tim      (upd_tim),
    .upd_cal      (upd_cal),
    .ack          (ack),
    .sec_evt      (sec_evt),
    .nv_tim       (nv_tim),
    .nv_cal       (nv_cal)
  );

  bcd_rtc_time_cnt u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .run      (time_run),
    .load     (time_load),
    .load_val (time_load_val),
    .time_q   (time_q),
    .day_carry(day_carry)
  );

  bcd_rtc_cal_cnt #(
    .RESET_CAL(RESET_CAL)
  ) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (day_step),
    .load    (cal_load),
    .load_val(cal_load_val),
    .cal_q   (cal_q)
  );

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        ack,
  input logic        upd_tim,
  input logic        upd_cal,
  input logic        sec_evt,
  input logic        nv_tim,
  input logic        nv_cal,
  input logic        time_load,
  input logic        cal_load,
  input logic [31:0] time_word,
  input logic [31:0] cal_word
);

  // R6
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (upd_tim || upd_cal));

  // R6
  ack_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(tick));

  // R5
  time_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tim && !time_load) |=> $stable(time_word));

  // R5
  cal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_cal && !cal_load) |=> $stable(cal_word));

  // R8
  sec_evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sec_evt);

  // R9
  bad_time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_tim && !time_load) |=> $stable(time_word));

  // R9
  bad_cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_cal && !cal_load) |=> $stable(cal_word));

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_word[6:0] <= 7'h59) && (time_word[3:0] <= 4'd9));

  // R10
  time_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_word[31:22] == 10'd0) && !time_word[15] && !time_word[7]);

endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (sec_tick),
  .ack      (ack),
  .upd_tim  (upd_tim),
  .upd_cal  (upd_cal),
  .sec_evt  (sec_evt),
  .nv_tim   (nv_tim),
  .nv_cal   (nv_cal),
  .time_load(time_load),
  .cal_load (cal_load),
  .time_word(time_word),
  .cal_word (cal_word)
);

// File: tb/bcd_rtc_bench.sv
`timescale 1ns/1ps
module bcd_rtc_bench;

  localparam logic [2:0] R_CTRL  = 3'd0;
  localparam logic [2:0] R_STAT  = 3'd1;
  localparam logic [2:0] R_CLR   = 3'd2;
  localparam logic [2:0] R_TIME  = 3'd3;
  localparam logic [2:0] R_CAL   = 3'd4;
  localparam logic [2:0] R_VALID = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        smp;

  always #5 clk = ~clk;

  bcd_rtc u_bcd_rtc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops one expected item per sample event
  initial begin
    forever begin
      @(smp);
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: got %h expected nothing", bus_rdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_addr = a;
    #2;
    -> smp;
    #1;
  endtask

  // request both freezes, wait for acknowledge, load, release
  task automatic set_clock(input logic [31:0] t, input logic [31:0] c);
    wr(R_CTRL, 32'h3);
    tick();
    wr(R_TIME, t);
    wr(R_CAL, c);
    wr(R_CTRL, 32'h0);
    wr(R_CLR, 32'h4);
  endtask

  // preset the eve of a day change, step once, check the new date
  task automatic day_step(input logic [31:0] c, input logic [31:0] e, input string t);
    set_clock(32'h0023_5959, c);
    tick();
    expect_rd(R_CAL, e, t);
    expect_rd(R_TIME, 32'h0, t);
    wr(R_CLR, 32'h4);
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(R_CTRL,  32'h0,         "R1 ctrl");
    expect_rd(R_STAT,  32'h0,         "R1 status");
    expect_rd(R_TIME,  32'h0,         "R1 time");
    expect_rd(R_CAL,   32'h0121_0019, "R1 cal");
    expect_rd(R_VALID, 32'h0,         "R1 valid");

    // R2 / R8 first second
    tick();
    expect_rd(R_TIME, 32'h1, "R2 one second");
    expect_rd(R_STAT, 32'h4, "R8 event set");
    wr(R_CLR, 32'h4);
    expect_rd(R_STAT, 32'h0, "R8 event cleared");

    // R8 tick and clear in the same cycle
    @(negedge clk);
    sec_tick = 1'b1; bus_wr = 1'b1; bus_addr = R_CLR; bus_wdata = 32'h4;
    @(negedge clk);
    sec_tick = 1'b0; bus_wr = 1'b0;
    expect_rd(R_STAT, 32'h4, "R8 tick beats clear");
    wr(R_CLR, 32'h4);

    // R2 minute carry: 58 more seconds from 00:00:02
    for (int i = 0; i < 58; i++) tick();
    expect_rd(R_TIME, 32'h0000_0100, "R2 minute carry");
    wr(R_CLR, 32'h4);

    // R7 write without request is ignored
    wr(R_TIME, 32'h0012_3456);
    expect_rd(R_TIME, 32'h0000_0100, "R7 ignored time write");

    // R6 / R5 time-only request
    wr(R_CTRL, 32'h1);
    expect_rd(R_STAT, 32'h0, "R6 no ack before tick");
    tick();
    expect_rd(R_STAT, 32'h5, "R6 ack on tick");
    expect_rd(R_TIME, 32'h0000_0100, "R5 time frozen");
    wr(R_TIME, 32'h0023_5959);
    expect_rd(R_TIME, 32'h0023_5959, "R7 time loaded");
    wr(R_CAL, 32'h2842_2320);
    expect_rd(R_CAL, 32'h0121_0019, "R7 cal write without cal request");
    wr(R_CTRL, 32'h0);
    expect_rd(R_STAT, 32'h4, "R6 ack drops with request");
    wr(R_CLR, 32'h4);
    tick();
    expect_rd(R_TIME, 32'h0, "R2 midnight wrap");
    expect_rd(R_CAL, 32'h0241_0019, "R3 day carry");
    wr(R_CLR, 32'h4);

    // R5 calendar frozen, time running: day carry dropped
    set_clock(32'h0023_5958, 32'h0241_0019);
    wr(R_CTRL, 32'h2);
    tick();
    tick();
    expect_rd(R_TIME, 32'h0, "R5 time runs under cal freeze");
    expect_rd(R_CAL, 32'h0241_0019, "R5 carry dropped");
    wr(R_CTRL, 32'h0);
    wr(R_CLR, 32'h4);

    // R3 month ends
    day_step(32'h2842_2320, 32'h0163_2320, "R3 Feb 2023 end");
    day_step(32'h3024_2320, 32'h0145_2320, "R3 30-day month end");
    // R4 leap years
    day_step(32'h28E2_2420, 32'h2922_2420, "R4 2024 Feb 29 and R3 dow wrap");
    day_step(32'h2922_2420, 32'h0143_2420, "R4 2024 Feb end");
    day_step(32'h2822_0019, 32'h0143_0019, "R4 1900 not leap");
    day_step(32'h2822_0020, 32'h2942_0020, "R4 2000 leap");
    // R3 century step
    day_step(32'h31B2_9919, 32'h01C1_0020, "R3 year and century wrap");

    // R9 invalid time entries
    set_clock(32'h0, 32'h01C1_0020);
    wr(R_CTRL, 32'h1);
    tick();
    wr(R_TIME, 32'h0024_0000);
    expect_rd(R_VALID, 32'h1, "R9 hour out of range");
    wr(R_TIME, 32'h0000_005A);
    expect_rd(R_VALID, 32'h1, "R9 bad digit");
    expect_rd(R_TIME, 32'h0, "R9 value not loaded");
    wr(R_CTRL, 32'h0);
    tick();
    expect_rd(R_TIME, 32'h0, "R9 held after release");
    wr(R_CTRL, 32'h1);
    tick();
    wr(R_TIME, 32'h0000_0010);
    expect_rd(R_VALID, 32'h0, "R9 flag cleared");
    wr(R_CTRL, 32'h0);
    tick();
    expect_rd(R_TIME, 32'h0000_0011, "R9 counting resumes");

    // R9 invalid calendar entry
    wr(R_CTRL, 32'h2);
    tick();
    wr(R_CAL, 32'h3042_2320);
    expect_rd(R_VALID, 32'h2, "R9 Feb 30 refused");
    expect_rd(R_CAL, 32'h01C1_0020, "R9 cal not loaded");
    wr(R_CAL, 32'h1542_2320);
    expect_rd(R_VALID, 32'h0, "R9 cal flag cleared");
    expect_rd(R_CAL, 32'h1542_2320, "R9 cal loaded");
    wr(R_CTRL, 32'h0);

    // R10 spare bits and AM/PM bit read zero
    wr(R_CTRL, 32'h1);
    tick();
    wr(R_TIME, 32'hFF40_9090 & 32'hFFFF_7F7F | 32'h0000_1010);
    expect_rd(R_TIME, 32'h0000_1010, "R10 spare bits zero");

    // R6 ack cleared by clear command
    expect_rd(R_STAT, 32'h5, "R6 ack held");
    wr(R_CLR, 32'h1);
    expect_rd(R_STAT, 32'h4, "R6 ack cleared by command");
    wr(R_CTRL, 32'h0);

    report();
  end

endmodule